// File: doc/BRIEF.md
# Modulo-Adder Self-Test Engine

This block tests a residue-number adder for the modulus m = 2^N - 2^K - 1 (239 with the default N=8, K=4) on its own. Two pseudo-random generators run from software-chosen seeds. Each generator has its own feedback polynomial. Their outputs are folded into valid residues and applied together to the adder under test, one pair per clock. Every adder result is registered next to a reference residue sum that the engine forms directly from the same operands. The two are compared on the following cycle.

A single start pulse launches a fixed run of operand pairs. When the last comparison has been made, the engine raises a done level. It also reports a sticky fail flag and the number of mismatching results. The adder under test is a prefix-tree design. It selects between A+B and A+B+2^K+1, depending on whether the second sum leaves N bits. A build parameter can clear one result bit of this adder, so that the engine's ability to catch a broken adder can itself be shown.

Top module: `modbist_top`

## Requirements
- R1: Each operand generator is an N-bit Fibonacci shift register. On each step the state shifts one place toward the MSB, and the new bit 0 is the XOR of the state bits selected by its tap mask (0xB8 for operand A, 0xE1 for operand B). On an accepted start it loads its seed. An all-zero seed is replaced by 0x01.
- R2: A generator state at or above the modulus has the modulus subtracted once before it reaches the adder, so both operands always lie in 0..m-1.
- R3: With the fault parameter off, the adder under test returns (A+B) mod m for every operand pair, so a full run ends with zero mismatches.
- R4: Each adder result is compared, one cycle after it is registered, with the reference sum of the same operands. Every mismatch adds one to the mismatch count.
- R5: The fail flag rises on the first mismatch and stays high until the next accepted start. An accepted start clears it and the mismatch count.
- R6: A run applies exactly RUN_LEN (255) operand pairs, starting from the seed values. Done rises on the 256th rising edge after the edge that accepts start. It stays high until the next accepted start and is low while a run is in progress.
- R7: A start pulse during a run, including the final pending comparison, is ignored. The run keeps its seeds and its finishing time.
- R8: After reset, done, fail and the mismatch count are all 0.
- R9: With the fault parameter on, bit K of the adder result is forced to 0. The mismatch count then equals the number of pairs whose true residue sum has bit K set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a run; sampled on the rising edge |
| seed_a_i | input | 8 | Seed for the operand A generator |
| seed_b_i | input | 8 | Seed for the operand B generator |
| done_o | output | 1 | Run finished; held until the next start |
| fail_o | output | 1 | Sticky: at least one mismatch in this run |
| err_cnt_o | output | 8 | Number of mismatching results in this run |

## Verification
The bench replays both generators and the residue arithmetic in its own code. It predicts the finishing cycle and, for a copy built with the fault on, the exact mismatch count. An off-by-one run length would move done by a cycle. A skipped seed value or a lost first comparison would change the faulty copy's count. The seeds include all zeros, values above the modulus, and identical seeds for both generators. A generator that locks up at zero, or an operand that is not folded, would give wrong sums and nonzero counts on the clean copy. A start pulse issued mid-run must leave the finishing time and the count unchanged; a design that restarts would finish late with a different count. The bench also checks that fail and the count clear right at a new start, which catches a flag that stays set from the previous run.

// File: rtl/modbist_pkg.sv
package modbist_pkg;

  // Reduce a value below 2*m into the residue range with one subtraction.
  function automatic int fold_residue(input int v, input int m);
    return (v >= m) ? v - m : v;
  endfunction

  // Reference residue sum: a plain wide sum, corrected once.
  function automatic int ref_modsum(input int a, input int b, input int m);
    int s;
    s = a + b;
    return (s >= m) ? s - m : s;
  endfunction

endpackage

// File: rtl/lfsr_gen.sv
module lfsr_gen #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = W'('hB8)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st;
  logic         fb;

  assign fb = ^(st & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st <= W'(1);
    else if (load_i) st <= (seed_i == '0) ? W'(1) : seed_i;
    else if (step_i) st <= {st[W-2:0], fb};
  end

  assign state_o = st;

  a_r1_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st != '0);
  a_r1_shift_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> st[W-1:1] == $past(st[W-2:0]));
endmodule

// File: rtl/pfx_add.sv
module pfx_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] s_o,
  output logic         cout_o
);
  localparam int LV = (W < 2) ? 1 : $clog2(W);

  logic [W-1:0] g0, p0, gf, pf;
  logic [W:0]   c;

  assign g0 = x_i & y_i;
  assign p0 = x_i ^ y_i;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int D = 1 << l;
    logic [W-1:0] gi, pi, go, po;
    if (l == 0) begin : g_first
      assign gi = g0;
      assign pi = p0;
    end else begin : g_next
      assign gi = g_lvl[l-1].go;
      assign pi = g_lvl[l-1].po;
    end
    always_comb begin
      go = gi;
      po = pi;
      for (int i = D; i < W; i++) begin
        go[i] = gi[i] | (pi[i] & gi[i-D]);
        po[i] = pi[i] & pi[i-D];
      end
    end
  end

  assign gf = g_lvl[LV-1].go;
  assign pf = g_lvl[LV-1].po;

  always_comb begin
    c[0] = cin_i;
    for (int i = 1; i <= W; i++) c[i] = gf[i-1] | (pf[i-1] & cin_i);
  end

  assign s_o    = p0 ^ c[W-1:0];
  assign cout_o = c[W];
endmodule

// File: rtl/modadd_core.sv
module modadd_core #(
  parameter int N        = 8,
  parameter int K        = 4,
  parameter bit FAULT_EN = 1'b0
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] sum_o
);
  localparam logic [N:0] OFFS = (N+1)'((1 << K) + 1);

  logic [N-1:0] s_ab;
  logic         co_ab;
  logic [N:0]   csa_s, csa_c, s_abt;
  logic         co_abt;
  logic [N-1:0] maj;
  logic         wrap;
  logic [N-1:0] clean;

  pfx_add #(.W(N)) u_ab (
    .x_i(a_i), .y_i(b_i), .cin_i(1'b0), .s_o(s_ab), .cout_o(co_ab)
  );

  // Carry-save step folding the constant offset 2^K+1 into the operands.
  assign maj   = (a_i & b_i) | (a_i & OFFS[N-1:0]) | (b_i & OFFS[N-1:0]);
  assign csa_s = {1'b0, a_i ^ b_i} ^ OFFS;
  assign csa_c = {maj, 1'b0};

  pfx_add #(.W(N+1)) u_abt (
    .x_i(csa_s), .y_i(csa_c), .cin_i(1'b0), .s_o(s_abt), .cout_o(co_abt)
  );

  assign wrap  = s_abt[N];
  assign clean = wrap ? s_abt[N-1:0] : s_ab;

  if (FAULT_EN) begin : g_fault
    always_comb begin
      sum_o    = clean;
      sum_o[K] = 1'b0;
    end
  end else begin : g_ok
    assign sum_o = clean;
  end

  always_comb begin
    a_r3_no_lost_carry: assert (wrap || !co_ab);
    a_r3_offset_sum_fits: assert (!co_abt);
  end
endmodule

// File: rtl/modbist_top.sv
module modbist_top #(
  parameter int           N        = 8,
  parameter int           K        = 4,
  parameter int           RUN_LEN  = 255,
  parameter logic [N-1:0] TAPS_A   = N'('hB8),
  parameter logic [N-1:0] TAPS_B   = N'('hE1),
  parameter bit           FAULT_EN = 1'b0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [N-1:0]                 seed_a_i,
  input  logic [N-1:0]                 seed_b_i,
  output logic                         done_o,
  output logic                         fail_o,
  output logic [$clog2(RUN_LEN+1)-1:0] err_cnt_o
);
  import modbist_pkg::*;

  localparam int M  = (1 << N) - (1 << K) - 1;
  localparam int CW = (RUN_LEN < 2) ? 1 : $clog2(RUN_LEN);
  localparam int EW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic          run, r_vld, r_last;
  logic [CW-1:0] cnt;
  logic [N-1:0]  st_a, st_b, opa, opb, dut_sum, gold;
  logic [N-1:0]  r_sum, r_gold;
  logic          start_go, miss;
  logic [EW-1:0] err;

  // Start is taken only when neither operands nor a comparison are pending.
  assign start_go = start_i && !run && !r_vld;

  lfsr_gen #(.W(N), .TAPS(TAPS_A)) u_gen_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start_go), .seed_i(seed_a_i),
    .step_i(run), .state_o(st_a)
  );
  lfsr_gen #(.W(N), .TAPS(TAPS_B)) u_gen_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start_go), .seed_i(seed_b_i),
    .step_i(run), .state_o(st_b)
  );

  assign opa  = N'(fold_residue(int'(st_a), M));
  assign opb  = N'(fold_residue(int'(st_b), M));
  assign gold = N'(ref_modsum(int'(opa), int'(opb), M));

  modadd_core #(.N(N), .K(K), .FAULT_EN(FAULT_EN)) u_add (
    .a_i(opa), .b_i(opb), .sum_o(dut_sum)
  );

  // Sequencer: counts applied pairs.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start_go) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) run <= 1'b0;
    end
  end

  // Result and reference capture stage.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_vld  <= 1'b0;
      r_last <= 1'b0;
      r_sum  <= '0;
      r_gold <= '0;
    end else if (start_go) begin
      r_vld  <= 1'b0;
      r_last <= 1'b0;
    end else begin
      r_vld  <= run;
      r_last <= run && (cnt == LAST);
      if (run) begin
        r_sum  <= dut_sum;
        r_gold <= gold;
      end
    end
  end

  assign miss = r_vld && (r_sum != r_gold);

  // Compare stage: sticky fail, mismatch count, done.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o <= 1'b0;
      err    <= '0;
      done_o <= 1'b0;
    end else if (start_go) begin
      fail_o <= 1'b0;
      err    <= '0;
      done_o <= 1'b0;
    end else begin
      if (miss) begin
        fail_o <= 1'b1;
        err    <= err + 1'b1;
      end
      if (r_vld && r_last) done_o <= 1'b1;
    end
  end

  assign err_cnt_o = err;

  a_r2_operands_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (int'(opa) < M) && (int'(opb) < M));
  a_r3_result_is_residue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_vld |-> int'(r_sum) < M);
  a_r4_fail_matches_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o == (err != '0));
  a_r5_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_go) |=> fail_o);
  a_r6_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!run && !r_vld));
  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && run && cnt != LAST) |=> (run && cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/tb_modbist_top.sv
module tb_modbist_top;
  localparam int CLK_P = 10;
  localparam int M     = 239;
  localparam int KB    = 4;
  localparam int RUNS  = 255;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] seed_a = '0, seed_b = '0;
  logic       done, fail, done_f, fail_f;
  logic [7:0] err, err_f;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;

  typedef struct { int done_cyc; int bad_err; } exp_t;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  modbist_top dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seed_a_i(seed_a),
    .seed_b_i(seed_b), .done_o(done), .fail_o(fail), .err_cnt_o(err)
  );
  modbist_top #(.FAULT_EN(1'b1)) dut_flt (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seed_a_i(seed_a),
    .seed_b_i(seed_b), .done_o(done_f), .fail_o(fail_f), .err_cnt_o(err_f)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Bench model of the generators (R1) and of folding and residue sums (R2, R3).
  function automatic logic [7:0] step8(input logic [7:0] s, input logic [7:0] mask);
    return {s[6:0], ^(s & mask)};
  endfunction

  function automatic int count_bitk(input logic [7:0] sa, input logic [7:0] sb);
    logic [7:0] a, b;
    int cntk, va, vb, r;
    a = (sa == 0) ? 8'h01 : sa;
    b = (sb == 0) ? 8'h01 : sb;
    cntk = 0;
    for (int i = 0; i < RUNS; i++) begin
      va = (int'(a) >= M) ? int'(a) - M : int'(a);
      vb = (int'(b) >= M) ? int'(b) - M : int'(b);
      r  = (va + vb) % M;
      if (((r >> KB) & 1) == 1) cntk++;
      a = step8(a, 8'hB8);
      b = step8(b, 8'hE1);
    end
    return cntk;
  endfunction

  // Driver: pushes the expected outcome of a run, then launches it.
  task automatic run_test(input logic [7:0] sa, input logic [7:0] sb, input bit intrude);
    exp_t it;
    it.bad_err = count_bitk(sa, sb);
    @(negedge clk);
    seed_a = sa;
    seed_b = sb;
    start  = 1'b1;
    it.done_cyc = cyc + 257;
    q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    check("R5 fail cleared at start", int'(fail_f), 0);
    check("R5 count cleared at start", int'(err_f), 0);
    check("R6 done low during run", int'(done), 0);
    if (intrude) begin
      repeat (100) @(negedge clk);
      seed_a = ~sa;
      seed_b = sb + 8'd7;
      start  = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R7: the late pulse leaves the run in progress
      check("R7 run continues after mid-run start", int'(done), 0);
      repeat (154) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
    check("R6 done held after run", int'(done), 1);
    check("R5 fail held after run", int'(fail_f), 1);
  endtask

  // Monitor: pops an expected item when done rises and compares.
  initial begin
    logic prev;
    exp_t it;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (done && !prev) begin
        if (q.size() == 0) begin
          check("R6 unexpected done", 1, 0);
        end else begin
          it = q.pop_front();
          check("R6 done cycle", cyc, it.done_cyc);
          check("R3 clean mismatch count", int'(err), 0);
          check("R3 clean fail flag", int'(fail), 0);
          check("R9 faulty copy done with clean", int'(done_f), 1);
          check("R4 R9 faulty mismatch count", int'(err_f), it.bad_err);
          check("R5 faulty fail flag", int'(fail_f), (it.bad_err != 0) ? 1 : 0);
        end
      end
      prev = done;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset done", int'(done), 0);
    check("R8 reset fail", int'(fail), 0);
    check("R8 reset count", int'(err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 idle after reset", int'(done) + int'(fail_f) + int'(err_f), 0);
    run_test(8'h5A, 8'hC3, 1'b0);   // ordinary seeds
    run_test(8'h00, 8'h00, 1'b0);   // R1 zero seeds replaced
    run_test(8'hF0, 8'hEF, 1'b0);   // R2 seeds above the modulus
    run_test(8'h01, 8'h01, 1'b0);   // R1 same seed, different taps
    run_test(8'h3C, 8'h96, 1'b1);   // R7 start pulses during a run
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule